// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a 32-bit periodic interrupt timer behind a small word-addressed register bus. One down-counter advances on a single-cycle tick strobe while the timer is enabled. When the count reaches zero, the next tick reloads it. The reload value is either the programmed load register or the all-ones maximum, so the counter can be periodic or free-running. A compare register is checked on every counting tick. A match sets a sticky status flag, and that flag drives a registered interrupt output while compare interrupts are enabled.

Software controls the block through five registers. It can restart the count from a fresh value when it enables the timer, or resume from the held count. A load-register write can optionally overwrite the running count at once. A soft-reset command returns the registers to their defaults but keeps the run and mode bits, so an enabled timer keeps running.

The counter core is a three-state machine:
- **ST_HALT**: the timer is disabled.
- **ST_RUN**: the count is non-zero and each tick decrements it.
- **ST_AT_ZERO**: the count is zero and the next tick reloads it.

The state transitions are:
- **enable**: ST_HALT goes to ST_RUN, or to ST_AT_ZERO when the resulting count is zero.
- **reach-zero**: ST_RUN goes to ST_AT_ZERO.
- **reload**: ST_AT_ZERO goes to ST_RUN, or stays in ST_AT_ZERO when the reload value is zero.
- **disable**: any state goes to ST_HALT.
- **overwrite**: a direct load moves to ST_RUN or ST_AT_ZERO depending on the loaded value.

Top module: `pit_timer`

## Requirements
- R1: Hard reset (rst_n low) gives these values: control 0, status 0, load 0xFFFFFFFF, compare 0, count 0xFFFFFFFF, irq 0.
- R2: Registers sit at word offset = byte address >> 2: 0 control, 1 status, 2 load, 3 compare, 4 count (read-only). A control write keeps only bits 25:0, and bits 31:26 read as zero. Reads of unmapped words return 0. An access whose byte address has bits 1:0 non-zero writes nothing and reads 0. Control bits: run (EN) 0, fresh-start 1, compare-irq-enable 2, reload-select 3, soft-reset 16, overwrite 17, and the kept mode bits 18, 19, 20, 21.
- R3: While EN=1, each tick decrements the count by one. While EN=0, ticks leave the count unchanged.
- R4: A tick that finds the count at zero reloads it: from the load register when reload-select=1, otherwise with 0xFFFFFFFF.
- R5: A control write that changes EN from 0 to 1 with fresh-start=1 loads the count (load register if reload-select=1, else 0xFFFFFFFF). With fresh-start=0 the held count resumes.
- R6: A load-register write copies the value into the count in the same cycle when overwrite=1. Otherwise the count is unchanged.
- R7: With EN=1 and compare-irq-enable=1, a tick that makes the count equal to compare sets status bit 0. This includes compare=0 at the wrap point.
- R8: No match is flagged while compare-irq-enable=0 or EN=0, even when the count equals compare.
- R9: Status bit 0 is sticky. Writing 1 to bit 0 of word 1 clears it, and writing 0 has no effect. A match in the same cycle as a clear leaves it set.
- R10: irq equals (status AND compare-irq-enable), delayed by one register stage.
- R11: A control write with soft-reset=1 clears status, sets load to 0xFFFFFFFF, clears compare and sets the count to 0xFFFFFFFF. Control bits 0, 1, 18, 19, 20 and 21 take the written values, and all others (soft-reset included) become 0. A running timer keeps counting.
- R12: With reload-select=1 and load 0, every tick keeps the count at 0. With compare 0 and compare-irq-enable=1, each such tick is a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count strobe, one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Registered compare interrupt |

## Verification
The hardest situation to reach is a compare match and a status clear landing on the same clock edge. At the ports this requires a tick and a status write in one cycle, exactly when the count steps onto the compare value. The stimulus sets up this collision on purpose. It enables overwrite, writes load 1 to place the count one tick above a zero compare value, and then drives the tick and the clear-status write together in a single cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CTRL_W = 26;

    // control bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_FRESH   = 1;
    localparam int CB_CMPIE   = 2;
    localparam int CB_RELOAD  = 3;
    localparam int CB_SOFTRST = 16;
    localparam int CB_OVERWR  = 17;
    localparam int CB_DBG     = 18;
    localparam int CB_WAIT    = 19;
    localparam int CB_DOZE    = 20;
    localparam int CB_STOP    = 21;

    // bits that survive a soft reset
    localparam logic [CTRL_W-1:0] KEEP_MASK =
        (CTRL_W'(1) << CB_RUN)  | (CTRL_W'(1) << CB_FRESH) |
        (CTRL_W'(1) << CB_DBG)  | (CTRL_W'(1) << CB_WAIT)  |
        (CTRL_W'(1) << CB_DOZE) | (CTRL_W'(1) << CB_STOP);

    // word offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_LOAD = 2;
    localparam int OFS_CMP  = 3;
    localparam int OFS_CNT  = 4;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_AT_ZERO = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        LD_NONE    = 2'd0,
        LD_SOFTRST = 2'd1,
        LD_START   = 2'd2,
        LD_OVERWR  = 2'd3
    } load_src_e;

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                match,
    input  logic [DATA_W-1:0]   cnt_q,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic [DATA_W-1:0]   load_q,
    output logic [DATA_W-1:0]   cmp_q,
    output logic                sts_q,
    output logic                en_nxt,
    output logic                ld_req,
    output logic [DATA_W-1:0]   ld_data
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic [CTRL_W-1:0] ctrl_wval, ctrl_d;
    logic              swr, en_rise;
    load_src_e         ld_src;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    assign wr_ctrl = bus_we && aligned && (word == WORD_W'(OFS_CTRL));
    assign wr_stat = bus_we && aligned && (word == WORD_W'(OFS_STAT));
    assign wr_load = bus_we && aligned && (word == WORD_W'(OFS_LOAD));
    assign wr_cmp  = bus_we && aligned && (word == WORD_W'(OFS_CMP));

    assign ctrl_wval = bus_wdata[CTRL_W-1:0];
    assign swr       = wr_ctrl && ctrl_wval[CB_SOFTRST];
    assign ctrl_d    = swr ? (ctrl_wval & KEEP_MASK) : ctrl_wval;
    assign en_nxt    = wr_ctrl ? ctrl_d[CB_RUN] : ctrl_q[CB_RUN];
    assign en_rise   = wr_ctrl && !ctrl_q[CB_RUN] && ctrl_d[CB_RUN];

    // select the source of a direct counter load
    always_comb begin
        if (swr) begin
            ld_src = LD_SOFTRST;
        end else if (en_rise && ctrl_d[CB_FRESH]) begin
            ld_src = LD_START;
        end else if (wr_load && ctrl_q[CB_OVERWR]) begin
            ld_src = LD_OVERWR;
        end else begin
            ld_src = LD_NONE;
        end
    end

    always_comb begin
        ld_req  = 1'b1;
        ld_data = ALL_ONES;
        unique case (ld_src)
            LD_NONE: begin
                ld_req  = 1'b0;
                ld_data = cnt_q;
            end
            LD_SOFTRST: ld_data = ALL_ONES;
            LD_START:   ld_data = ctrl_d[CB_RELOAD] ? load_q : ALL_ONES;
            LD_OVERWR:  ld_data = bus_wdata;
            default:    ld_req  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (swr) begin
            sts_q <= 1'b0;
        end else if (match) begin
            sts_q <= 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            sts_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= ALL_ONES;
        end else if (swr) begin
            load_q <= ALL_ONES;
        end else if (wr_load) begin
            load_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (swr) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= bus_wdata;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                WORD_W'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_q);
                WORD_W'(OFS_STAT): bus_rdata = DATA_W'(sts_q);
                WORD_W'(OFS_LOAD): bus_rdata = load_q;
                WORD_W'(OFS_CMP):  bus_rdata = cmp_q;
                WORD_W'(OFS_CNT):  bus_rdata = cnt_q;
                default:           bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pit_cnt_fsm.sv
module pit_cnt_fsm
    import pit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en_nxt,
    input  logic              rld,
    input  logic              ocien,
    input  logic              ld_req,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [DATA_W-1:0] load_q,
    input  logic [DATA_W-1:0] cmp_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              match
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    cnt_state_e        state_q, state_nxt;
    logic [DATA_W-1:0] cnt_nxt;
    logic              step;

    // next count and next state
    always_comb begin
        cnt_nxt = cnt_q;
        step    = 1'b0;
        if (ld_req) begin
            cnt_nxt = ld_data;
        end else if (tick) begin
            unique case (state_q)
                ST_HALT: begin
                    cnt_nxt = cnt_q;
                end
                ST_RUN: begin
                    cnt_nxt = cnt_q - ONE;
                    step    = 1'b1;
                end
                ST_AT_ZERO: begin
                    cnt_nxt = rld ? load_q : ALL_ONES;
                    step    = 1'b1;
                end
                default: begin
                    cnt_nxt = cnt_q;
                end
            endcase
        end

        if (!en_nxt) begin
            state_nxt = ST_HALT;
        end else if (cnt_nxt == '0) begin
            state_nxt = ST_AT_ZERO;
        end else begin
            state_nxt = ST_RUN;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= ALL_ONES;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        match = step && ocien && (cnt_nxt == cmp_q);
    end

endmodule

// File: rtl/pit_irq.sv
module pit_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sts,
    input  logic ocien,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= sts && ocien;
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] load_q, cmp_q, cnt_q, ld_data;
    logic              sts_q, en_nxt, ld_req, match;

    pit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .match     (match),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .load_q    (load_q),
        .cmp_q     (cmp_q),
        .sts_q     (sts_q),
        .en_nxt    (en_nxt),
        .ld_req    (ld_req),
        .ld_data   (ld_data)
    );

    pit_cnt_fsm #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en_nxt  (en_nxt),
        .rld     (ctrl_q[CB_RELOAD]),
        .ocien   (ctrl_q[CB_CMPIE]),
        .ld_req  (ld_req),
        .ld_data (ld_data),
        .load_q  (load_q),
        .cmp_q   (cmp_q),
        .cnt_q   (cnt_q),
        .match   (match)
    );

    pit_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .sts   (sts_q),
        .ocien (ctrl_q[CB_CMPIE]),
        .irq   (irq)
    );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] count,
    input logic              status,
    input logic              run_en,
    input logic              ocien
);

    localparam int WORD_W = ADDR_W - 2;

    logic clr_wr, srst_wr;
    assign clr_wr  = bus_we && (bus_addr == ADDR_W'(4)) && bus_wdata[0];
    assign srst_wr = bus_we && (bus_addr == ADDR_W'(0)) && bus_wdata[16];

    p_ctrl_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata[DATA_W-1:26] == '0));

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !bus_we) |=> (count == $past(count)));

    p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !bus_we && count != '0) |=> (count == $past(count) - DATA_W'(1)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_wr && !srst_wr) |=> status);

    p_no_match_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ocien && !status) |=> !status);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ocien) && $past(status)));

    logic unused_ok;
    assign unused_ok = ^{bus_addr[WORD_W+1:2], tick};

endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (cnt_q),
    .status    (sts_q),
    .run_en    (ctrl_q[0]),
    .ocien     (ctrl_q[2])
);

// File: tb/test_pit_timer.sv
module test_pit_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_STAT = 12'h004;
    localparam logic [11:0] A_LOAD = 12'h008;
    localparam logic [11:0] A_CMP  = 12'h00C;
    localparam logic [11:0] A_CNT  = 12'h010;

    always #5 clk = ~clk;

    pit_timer i_pit_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'd2, 12'h000, 32'hFFFE_FFF0, 12'h000, 32'h03FE_FFF0}, // R2 upper bits dropped
        '{4'd2, 12'h000, 32'h0000_0000, 12'h000, 32'h0000_0000}, // R2
        '{4'd6, 12'h008, 32'h1234_5678, 12'h010, 32'hFFFF_FFFF}, // R6 no overwrite
        '{4'd2, 12'h00C, 32'hA5A5_0000, 12'h00C, 32'hA5A5_0000}, // R2 compare
        '{4'd2, 12'h008, 32'h0000_0055, 12'h008, 32'h0000_0055}, // R2 load
        '{4'd2, 12'h01C, 32'h0000_0001, 12'h01C, 32'h0000_0000}, // R2 unmapped
        '{4'd2, 12'h010, 32'h0000_0000, 12'h010, 32'hFFFF_FFFF}, // R2 count read-only
        '{4'd9, 12'h004, 32'h0000_0001, 12'h004, 32'h0000_0000}, // R9 clear when clear
        '{4'd2, 12'h009, 32'h0000_0077, 12'h008, 32'h0000_0055}  // R2 misaligned ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [11:0] a, input logic [31:0] expv);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, expv);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk_reg("R1 ctrl", A_CTRL, 32'h0);
        chk_reg("R1 status", A_STAT, 32'h0);
        chk_reg("R1 load", A_LOAD, 32'hFFFF_FFFF);
        chk_reg("R1 cmp", A_CMP, 32'h0);
        chk_reg("R1 count", A_CNT, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // table walk
        for (int v = 0; v < 9; v++) begin
            wr(VECS[v].waddr, VECS[v].wdata);
            chk_reg($sformatf("R%0d vec %0d", VECS[v].req, v), VECS[v].raddr, VECS[v].expv);
        end

        // R5 fresh start with reload-select, R3 counting, R4 wrap
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'hB);
        chk_reg("R5 fresh start from load", A_CNT, 32'd5);
        ticks(2);
        chk_reg("R3 decrement", A_CNT, 32'd3);
        ticks(3);
        chk_reg("R4 reached zero", A_CNT, 32'd0);
        ticks(1);
        chk_reg("R4 reload from load", A_CNT, 32'd5);

        // R3 halted ticks
        wr(A_CTRL, 32'h0);
        ticks(4);
        chk_reg("R3 hold while disabled", A_CNT, 32'd5);

        // R5 resume and R6 no overwrite
        wr(A_LOAD, 32'd9);
        chk_reg("R6 count untouched", A_CNT, 32'd5);
        wr(A_CTRL, 32'h9);
        chk_reg("R5 resume held count", A_CNT, 32'd5);
        ticks(1);
        chk_reg("R3 resumed decrement", A_CNT, 32'd4);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'hB);
        chk_reg("R5 restart from load", A_CNT, 32'd9);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h3);
        chk_reg("R5 restart from max", A_CNT, 32'hFFFF_FFFF);

        // R6 overwrite, R4 free-run reload
        wr(A_CTRL, 32'h0002_0003);
        wr(A_LOAD, 32'd2);
        chk_reg("R6 overwrite count", A_CNT, 32'd2);
        ticks(2);
        ticks(1);
        chk_reg("R4 free-run reload max", A_CNT, 32'hFFFF_FFFF);

        // R7 compare match, R10 irq timing
        wr(A_CTRL, 32'h0);
        wr(A_CMP, 32'd3);
        wr(A_LOAD, 32'd6);
        wr(A_CTRL, 32'hF);
        chk_reg("R5 count after start", A_CNT, 32'd6);
        ticks(2);
        chk_reg("R7 no early match", A_STAT, 32'd0);
        ticks(1);
        chk_reg("R7 match sets status", A_STAT, 32'd1);
        chk("R10 irq one stage late", {31'd0, irq}, 32'h0);
        cyc();
        chk("R10 irq asserted", {31'd0, irq}, 32'h1);

        // R9 clear semantics
        wr(A_STAT, 32'h0);
        chk_reg("R9 write 0 no effect", A_STAT, 32'd1);
        wr(A_STAT, 32'h1);
        chk_reg("R9 write 1 clears", A_STAT, 32'd0);
        cyc();
        chk("R10 irq drops", {31'd0, irq}, 32'h0);

        // R7 compare zero at wrap
        wr(A_CMP, 32'd0);
        ticks(2);
        chk_reg("R7 no match at 1", A_STAT, 32'd0);
        ticks(1);
        chk_reg("R7 zero compare at wrap", A_STAT, 32'd1);
        wr(A_STAT, 32'h1);
        ticks(1);
        chk_reg("R4 reload after wrap", A_CNT, 32'd6);
        chk_reg("R7 no match on reload", A_STAT, 32'd0);

        // R8 compare disabled
        wr(A_CTRL, 32'hB);
        ticks(6);
        chk_reg("R8 count at compare", A_CNT, 32'd0);
        chk_reg("R8 no match with irq-enable off", A_STAT, 32'd0);

        // R10 gating by compare-irq-enable
        wr(A_CTRL, 32'hF);
        ticks(7);
        chk_reg("R7 match after full period", A_STAT, 32'd1);
        cyc();
        chk("R10 irq on", {31'd0, irq}, 32'h1);
        wr(A_CTRL, 32'hB);
        cyc();
        chk("R10 irq gated off", {31'd0, irq}, 32'h0);
        chk_reg("R9 status kept", A_STAT, 32'd1);

        // R8 disabled timer
        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'h4);
        ticks(3);
        chk_reg("R8 no match when disabled", A_STAT, 32'd0);

        // R9 match and clear on the same edge
        wr(A_CTRL, 32'h0002_000F);
        wr(A_LOAD, 32'd1);
        chk_reg("R6 overwrite to 1", A_CNT, 32'd1);
        @(negedge clk);
        tick      = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = A_STAT;
        bus_wdata = 32'h1;
        @(negedge clk);
        tick      = 1'b0;
        bus_we    = 1'b0;
        chk_reg("R9 set wins over clear", A_STAT, 32'd1);
        chk_reg("R3 count stepped", A_CNT, 32'd0);

        // R11 soft reset
        wr(A_CTRL, 32'h03FF_FFFF);
        chk_reg("R11 ctrl kept bits", A_CTRL, 32'h003C_0003);
        chk_reg("R11 status", A_STAT, 32'd0);
        chk_reg("R11 load", A_LOAD, 32'hFFFF_FFFF);
        chk_reg("R11 cmp", A_CMP, 32'd0);
        chk_reg("R11 count", A_CNT, 32'hFFFF_FFFF);
        ticks(1);
        chk_reg("R11 keeps running", A_CNT, 32'hFFFF_FFFE);

        // R1 hard reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        cyc();
        chk_reg("R1 ctrl after reset", A_CTRL, 32'h0);
        chk_reg("R1 count after reset", A_CNT, 32'hFFFF_FFFF);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);

        // R12 zero load period
        wr(A_LOAD, 32'd0);
        wr(A_CTRL, 32'hF);
        chk_reg("R12 start at zero", A_CNT, 32'd0);
        chk_reg("R12 no match from start", A_STAT, 32'd0);
        ticks(1);
        chk_reg("R12 stays zero", A_CNT, 32'd0);
        chk_reg("R12 match each tick", A_STAT, 32'd1);
        wr(A_STAT, 32'h1);
        ticks(1);
        chk_reg("R12 match again", A_STAT, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule